// File: doc/BRIEF.md
# I2C Status Flag Register Logic

This block keeps the status flags of an I2C controller. The bus engine reports single-cycle events: start generated, acknowledge received, acknowledge missing, stop seen, arbitration lost, bus error and general-call match. The block turns these into sticky flags and serves them through two read-only status registers. Each flag has its own clear rule. Some flags clear when a status register is read. The start-sent flag clears only after a status read followed by a data register write. Every flag clears when the peripheral is disabled.

From the flags the block derives a registered interrupt request and an SCL hold-low request. The shifter, the pin drivers and the data register storage live elsewhere. The CPU side sees only an address, a read strobe and a write strobe. Addresses decode as 0 for status register 1, 1 for status register 2, 2 for the data register, and any other value for a register outside this block.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset both status registers read 00h, and the interrupt and hold requests are 0.
- R2: Status register 1 bit 1 (the mode bit) becomes 1 on the edge after a start request while enabled. It becomes 0 on the edge after a stop event or an arbitration-lost event. A start request in the same cycle takes priority.
- R3: Status register 1 bit 0 (start-sent) becomes 1 after a start-generated event. It clears only when a read of address 0 is followed by a write to address 2, with no other write in between. A set event in the same cycle wins over the clear.
- R4: Status register 2 bit 4 (acknowledge failure) sets on a missing-acknowledge event and clears on a read of address 1.
- R5: Status register 2 bit 3 (stop-detected) sets on a stop event only if acknowledge enable is 1 and an acknowledge-received event has occurred since the last missing-acknowledge or stop event. A read of address 1 clears it.
- R6: Status register 2 bits 2, 1 and 0 (arbitration lost, bus error, general call) set on their events and clear on a read of address 1.
- R7: A flag whose set event arrives in the same cycle as the read that would clear it stays 1.
- R8: While peripheral enable is 0, all flags, including the mode bit, are 0 on the next edge, and events are ignored.
- R9: Status register 2 bits 7:5 and status register 1 bits 7:2 always read 0.
- R10: The interrupt request equals interrupt enable AND (start-sent OR acknowledge failure OR stop-detected), delayed by one clock.
- R11: The SCL hold request is start-sent OR the byte-finished input. Acknowledge failure and stop-detected do not raise it.
- R12: Writes to address 0 or 1 leave both status registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pe_en_i | input | 1 | Peripheral enable |
| start_req_i | input | 1 | Pulse: software wrote the start request |
| ack_en_i | input | 1 | Acknowledge enable control bit |
| irq_en_i | input | 1 | Interrupt enable control bit |
| ev_start_done_i | input | 1 | Pulse: start condition generated |
| ev_stop_i | input | 1 | Pulse: stop condition seen on the bus |
| ev_ack_i | input | 1 | Pulse: acknowledge received |
| ev_nack_i | input | 1 | Pulse: no acknowledge returned |
| ev_arb_lost_i | input | 1 | Pulse: arbitration lost |
| ev_bus_err_i | input | 1 | Pulse: misplaced start or stop |
| ev_gen_call_i | input | 1 | Pulse: general-call address matched |
| btf_i | input | 1 | Byte-finished flag from the transfer logic |
| reg_addr_i | input | ADDR_W | CPU register address |
| reg_rd_i | input | 1 | CPU read strobe |
| reg_wr_i | input | 1 | CPU write strobe |
| sr1_o | output | DATA_W | Status register 1 read value |
| sr2_o | output | DATA_W | Status register 2 read value |
| irq_o | output | 1 | Registered interrupt request |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
The hardest case to reach from the ports is the cancelled clear of start-sent. This needs a read of status register 1, then a write to a different register, then a data register write, all while start-sent is 1. Directed sequences build this order explicitly, and also the same-cycle collision of a set event with a clearing read. A long random phase with sparse event pulses and frequent register strobes then produces further interleavings. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    // Flags cleared by a read of status register 2, indexed by bit position
    localparam int unsigned RC_GCAL  = 0;
    localparam int unsigned RC_BERR  = 1;
    localparam int unsigned RC_ARLO  = 2;
    localparam int unsigned RC_STOPF = 3;
    localparam int unsigned RC_AF    = 4;
    localparam int unsigned NUM_RC   = 5;

    typedef struct packed {
        logic              mode;
        logic              sb;
        logic              sr1_seen;
        logic              ack_seen;
        logic [NUM_RC-1:0] rc;
    } flag_state_t;

    typedef struct packed {
        logic rd_sr1;
        logic rd_sr2;
        logic wr_dr;
        logic wr_any;
    } bus_dec_t;

endpackage

// File: rtl/i2c_stat_bus_dec.sv
module i2c_stat_bus_dec
    import i2c_stat_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned ADDR_S1 = 0,
    parameter int unsigned ADDR_S2 = 1,
    parameter int unsigned ADDR_DR = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output bus_dec_t          dec_o
);
    localparam logic [ADDR_W-1:0] A_S1 = ADDR_W'(ADDR_S1);
    localparam logic [ADDR_W-1:0] A_S2 = ADDR_W'(ADDR_S2);
    localparam logic [ADDR_W-1:0] A_DR = ADDR_W'(ADDR_DR);

    always_comb begin
        dec_o.rd_sr1 = rd_i && (addr_i == A_S1);
        dec_o.rd_sr2 = rd_i && (addr_i == A_S2);
        dec_o.wr_dr  = wr_i && (addr_i == A_DR);
        dec_o.wr_any = wr_i;
    end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        start_req_i,
    input  logic        ack_en_i,
    input  logic        ev_start_done_i,
    input  logic        ev_stop_i,
    input  logic        ev_ack_i,
    input  logic        ev_nack_i,
    input  logic        ev_arb_i,
    input  logic        ev_berr_i,
    input  logic        ev_gcal_i,
    input  bus_dec_t    dec_i,
    output flag_state_t st_o
);
    flag_state_t       st_d, st_q;
    logic [NUM_RC-1:0] rc_set;
    logic [NUM_RC-1:0] rc_next;

    always_comb begin
        rc_set           = '0;
        rc_set[RC_AF]    = ev_nack_i;
        rc_set[RC_STOPF] = ev_stop_i && ack_en_i && st_q.ack_seen;
        rc_set[RC_ARLO]  = ev_arb_i;
        rc_set[RC_BERR]  = ev_berr_i;
        rc_set[RC_GCAL]  = ev_gcal_i;
    end

    // Read-clear flags share one rule: a set event beats the clearing read
    for (genvar i = 0; i < NUM_RC; i++) begin : g_rc
        assign rc_next[i] = rc_set[i] | (st_q.rc[i] & ~dec_i.rd_sr2);
    end

    always_comb begin
        st_d = st_q;
        if (start_req_i)
            st_d.mode = 1'b1;
        else if (ev_stop_i || ev_arb_i)
            st_d.mode = 1'b0;

        if (ev_start_done_i)
            st_d.sb = 1'b1;
        else if (dec_i.wr_dr && st_q.sr1_seen)
            st_d.sb = 1'b0;

        // Any write ends the read-then-write sequence, used or not
        if (dec_i.wr_any)
            st_d.sr1_seen = 1'b0;
        else if (dec_i.rd_sr1)
            st_d.sr1_seen = 1'b1;

        if (ev_nack_i || ev_stop_i)
            st_d.ack_seen = 1'b0;
        else if (ev_ack_i)
            st_d.ack_seen = 1'b1;

        st_d.rc = rc_next;

        if (!en_i)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign st_o = st_q;

    assert_mode_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_req_i) |=> st_q.mode);

    assert_mode_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !start_req_i && (ev_stop_i || ev_arb_i)) |=> !st_q.mode);

    assert_sb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ev_start_done_i && !dec_i.wr_dr) |=> $stable(st_q.sb));

    assert_stop_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_en_i && !st_q.rc[RC_STOPF]) |=> !st_q.rc[RC_STOPF]);

    // R4 and R6: a read of status register 2 with no set event clears the flag
    for (genvar k = 0; k < NUM_RC; k++) begin : g_chk
        assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_i.rd_sr2 && !rc_set[k]) |=> !st_q.rc[k]);
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i && rc_set[k]) |=> st_q.rc[k]);
    end

    assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q == '0));
endmodule

// File: rtl/i2c_stat_out.sv
module i2c_stat_out
    import i2c_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en_i,
    input  logic              btf_i,
    input  logic              mode_i,
    input  logic              sb_i,
    input  logic [NUM_RC-1:0] rc_i,
    output logic [DATA_W-1:0] sr1_o,
    output logic [DATA_W-1:0] sr2_o,
    output logic              irq_o,
    output logic              scl_hold_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_en_i && (sb_i || rc_i[RC_AF] || rc_i[RC_STOPF]);
        sr1_o = '0;
        sr1_o[1] = mode_i;
        sr1_o[0] = sb_i;
        sr2_o = '0;
        sr2_o[NUM_RC-1:0] = rc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end

    assign irq_o      = irq_q;
    assign scl_hold_o = sb_i || btf_i;

    assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> !irq_o);

    assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && sb_i) |=> irq_o);

    assert_hold_sb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sb_i |-> scl_hold_o);
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_stat_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_S1 = 0,
    parameter int unsigned ADDR_S2 = 1,
    parameter int unsigned ADDR_DR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pe_en_i,
    input  logic              start_req_i,
    input  logic              ack_en_i,
    input  logic              irq_en_i,
    input  logic              ev_start_done_i,
    input  logic              ev_stop_i,
    input  logic              ev_ack_i,
    input  logic              ev_nack_i,
    input  logic              ev_arb_lost_i,
    input  logic              ev_bus_err_i,
    input  logic              ev_gen_call_i,
    input  logic              btf_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    output logic [DATA_W-1:0] sr1_o,
    output logic [DATA_W-1:0] sr2_o,
    output logic              irq_o,
    output logic              scl_hold_o
);
    bus_dec_t    dec;
    flag_state_t st;

    i2c_stat_bus_dec #(
        .ADDR_W (ADDR_W),
        .ADDR_S1(ADDR_S1),
        .ADDR_S2(ADDR_S2),
        .ADDR_DR(ADDR_DR)
    ) i_dec (
        .addr_i(reg_addr_i),
        .rd_i  (reg_rd_i),
        .wr_i  (reg_wr_i),
        .dec_o (dec)
    );

    i2c_stat_flags i_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (pe_en_i),
        .start_req_i    (start_req_i),
        .ack_en_i       (ack_en_i),
        .ev_start_done_i(ev_start_done_i),
        .ev_stop_i      (ev_stop_i),
        .ev_ack_i       (ev_ack_i),
        .ev_nack_i      (ev_nack_i),
        .ev_arb_i       (ev_arb_lost_i),
        .ev_berr_i      (ev_bus_err_i),
        .ev_gcal_i      (ev_gen_call_i),
        .dec_i          (dec),
        .st_o           (st)
    );

    i2c_stat_out #(
        .DATA_W(DATA_W)
    ) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_en_i  (irq_en_i),
        .btf_i     (btf_i),
        .mode_i    (st.mode),
        .sb_i      (st.sb),
        .rc_i      (st.rc),
        .sr1_o     (sr1_o),
        .sr2_o     (sr2_o),
        .irq_o     (irq_o),
        .scl_hold_o(scl_hold_o)
    );

    // R12: status register writes reach no flag; only reads and events move them
    assert_no_wr_effect_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_en_i && reg_wr_i && !reg_rd_i && !ev_nack_i && !ev_stop_i && !ev_arb_lost_i
         && !ev_bus_err_i && !ev_gen_call_i) |=> $stable(sr2_o));
endmodule

// File: tb/test_i2c_status_flags.sv
module test_i2c_status_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 0, start_req = 0, ack_en = 0, irq_en = 0;
    logic       ev_sd = 0, ev_stop = 0, ev_ack = 0, ev_nack = 0;
    logic       ev_arb = 0, ev_berr = 0, ev_gcal = 0, btf = 0;
    logic [1:0] addr = 0;
    logic       rd = 0, wr = 0;
    logic [7:0] sr1, sr2;
    logic       irq, hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit m_mode, m_sb, m_mark, m_acks, m_af, m_stop, m_arb, m_berr, m_gc, m_irq;

    always #5 clk = ~clk;

    i2c_status_flags i_i2c_status_flags (
        .clk(clk), .rst_n(rst_n), .pe_en_i(en), .start_req_i(start_req),
        .ack_en_i(ack_en), .irq_en_i(irq_en), .ev_start_done_i(ev_sd),
        .ev_stop_i(ev_stop), .ev_ack_i(ev_ack), .ev_nack_i(ev_nack),
        .ev_arb_lost_i(ev_arb), .ev_bus_err_i(ev_berr), .ev_gen_call_i(ev_gcal),
        .btf_i(btf), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
        .sr1_o(sr1), .sr2_o(sr2), .irq_o(irq), .scl_hold_o(hold)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_mode, m_sb, m_mark, m_acks, m_af, m_stop, m_arb, m_berr, m_gc, m_irq} = '0;
        end else begin
            bit r1, r2, wd;
            r1 = rd && addr == 2'd0;
            r2 = rd && addr == 2'd1;
            wd = wr && addr == 2'd2;
            m_irq = irq_en && (m_sb || m_af || m_stop);
            if (!en) begin
                {m_mode, m_sb, m_mark, m_acks, m_af, m_stop, m_arb, m_berr, m_gc} = '0;
            end else begin
                if (ev_stop && ack_en && m_acks) m_stop = 1; else if (r2) m_stop = 0;
                if (ev_nack || ev_stop) m_acks = 0; else if (ev_ack) m_acks = 1;
                if (start_req) m_mode = 1; else if (ev_stop || ev_arb) m_mode = 0;
                if (ev_sd) m_sb = 1; else if (wd && m_mark) m_sb = 0;
                if (wr) m_mark = 0; else if (r1) m_mark = 1;
                if (ev_nack) m_af = 1;  else if (r2) m_af = 0;
                if (ev_arb) m_arb = 1;  else if (r2) m_arb = 0;
                if (ev_berr) m_berr = 1; else if (r2) m_berr = 0;
                if (ev_gcal) m_gc = 1;  else if (r2) m_gc = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] e1, e2;
        e1 = {6'b0, m_mode, m_sb};
        e2 = {3'b0, m_af, m_stop, m_arb, m_berr, m_gc};
        chk(sr1 === e1, "R2 R3 R9 sr1", sr1, e1);
        chk(sr2 === e2, "R4 R5 R6 R9 sr2", sr2, e2);
        chk(irq === m_irq, "R10 irq", {7'b0, irq}, {7'b0, m_irq});
        chk(hold === (m_sb || btf), "R11 hold", {7'b0, hold}, {7'b0, m_sb || btf});
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk(sr1 == 0 && sr2 == 0, "R1 regs", sr1 | sr2, 8'h00);
        chk(!irq && !hold, "R1 requests", {6'b0, irq, hold}, 8'h00);
        rst_n = 1; en = 1; irq_en = 1; ack_en = 1;
        tick();
        start_req = 1; tick(); start_req = 0;
        chk(sr1 == 8'h02, "R2 mode set", sr1, 8'h02);
        ev_sd = 1; tick(); ev_sd = 0;
        chk(sr1 == 8'h03, "R3 start-sent set", sr1, 8'h03);
        chk(hold == 1, "R11 hold from start-sent", {7'b0, hold}, 8'h01);
        chk(irq == 0, "R10 irq latency", {7'b0, irq}, 8'h00);
        tick();
        chk(irq == 1, "R10 irq raised", {7'b0, irq}, 8'h01);
        // read SR1, intervening write, then data write: no clear
        addr = 0; rd = 1; tick(); rd = 0;
        addr = 3; wr = 1; tick();
        addr = 2; tick(); wr = 0;
        chk(sr1[0] == 1, "R3 cancelled clear", sr1, 8'h03);
        addr = 0; rd = 1; tick(); rd = 0;
        addr = 2; wr = 1; tick(); wr = 0;
        chk(sr1 == 8'h02, "R3 read-then-write clear", sr1, 8'h02);
        tick();
        chk(hold == 0 && irq == 0, "R11 R10 released", {6'b0, irq, hold}, 8'h00);
        // writes to status registers ignored
        ev_gcal = 1; tick(); ev_gcal = 0;
        addr = 1; wr = 1; tick();
        addr = 0; tick(); wr = 0;
        chk(sr2 == 8'h01, "R12 sr2 write", sr2, 8'h01);
        chk(sr1 == 8'h02, "R12 sr1 write", sr1, 8'h02);
        // stop after acknowledge
        ev_ack = 1; tick(); ev_ack = 0;
        ev_stop = 1; tick(); ev_stop = 0;
        chk(sr2 == 8'h09, "R5 stop-detected", sr2, 8'h09);
        chk(sr1 == 8'h00, "R2 mode cleared by stop", sr1, 8'h00);
        addr = 1; rd = 1; tick(); rd = 0;
        chk(sr2 == 8'h00, "R6 read clear", sr2, 8'h00);
        ev_nack = 1; tick(); ev_nack = 0;
        chk(sr2 == 8'h10, "R4 ack failure", sr2, 8'h10);
        chk(hold == 0, "R11 no hold from ack failure", {7'b0, hold}, 8'h00);
        ev_stop = 1; tick(); ev_stop = 0;
        chk(sr2 == 8'h10, "R5 stop after nack ignored", sr2, 8'h10);
        ack_en = 0; ev_ack = 1; tick(); ev_ack = 0;
        ev_stop = 1; tick(); ev_stop = 0; ack_en = 1;
        chk(sr2[3] == 0, "R5 ack disabled", sr2, 8'h10);
        ev_arb = 1; ev_berr = 1; tick(); ev_arb = 0;
        addr = 1; rd = 1; tick(); rd = 0; ev_berr = 0;
        chk(sr2 == 8'h02, "R7 set wins over read", sr2, 8'h02);
        rd = 1; tick(); rd = 0;
        chk(sr2 == 8'h00, "R6 cleared", sr2, 8'h00);
        start_req = 1; ev_sd = 1; ev_nack = 1; tick();
        start_req = 0; ev_sd = 0; ev_nack = 0;
        en = 0; ev_gcal = 1; tick(); ev_gcal = 0;
        chk(sr1 == 8'h00 && sr2 == 8'h00, "R8 disable", sr1 | sr2, 8'h00);
        en = 1; tick();
        for (int n = 0; n < 3000; n++) begin
            en        = ($urandom_range(0, 99) != 0);
            start_req = ($urandom_range(0, 19) == 0);
            ack_en    = ($urandom_range(0, 7) != 0);
            irq_en    = ($urandom_range(0, 5) != 0);
            ev_sd     = ($urandom_range(0, 11) == 0);
            ev_stop   = ($urandom_range(0, 11) == 0);
            ev_ack    = ($urandom_range(0, 4) == 0);
            ev_nack   = ($urandom_range(0, 13) == 0);
            ev_arb    = ($urandom_range(0, 17) == 0);
            ev_berr   = ($urandom_range(0, 17) == 0);
            ev_gcal   = ($urandom_range(0, 17) == 0);
            btf       = ($urandom_range(0, 5) == 0);
            addr      = 2'($urandom_range(0, 3));
            rd        = ($urandom_range(0, 2) == 0);
            wr        = ($urandom_range(0, 3) == 0);
            tick();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule